// File: doc/BRIEF.md
# Ordered Commit Store Queue

This block sits between a core's execution pipeline and its data cache and holds stores until they may be made visible. A store enters a slot when it executes, becomes eligible for the cache only after the pipeline declares it retired, and is then written to the cache through a request/grant port. Slots leave strictly oldest first. A store that has been written into a slot but not yet committed cannot be seen by any other agent.

Loads look up the queue by address. When one or more buffered stores match, the youngest of them supplies the data. Otherwise the load reads the cache combinationally, even while older stores to other addresses still wait. This is the only reordering the block permits: an older store may become visible after a younger load. Two fence inputs control ordering. The heavy fence holds younger loads and new stores until the queue is empty. The light fence orders loads only and finishes at once, without waiting for the queue to drain. A pipeline flush removes every slot that has not yet retired in a single cycle. Retired slots continue to drain after a flush.

Top module: `tso_store_buffer`

## Requirements
- R1: After a synchronous active-high reset the queue is empty: `st_ready`=1, `cwr_req`=0, `ld_hit`=0, `ld_block`=0.
- R2: A store is accepted on a cycle with `st_valid`=1, `st_ready`=1 and `flush`=0. `st_ready` is 0 whenever DEPTH (8) slots are occupied or `fence_full` is 1. A store offered while not ready is dropped.
- R3: `cwr_req` is 1 exactly when at least one retired slot is present. A slot that is not retired never reaches the cache port.
- R4: `cwr_addr`/`cwr_data` always show the oldest slot. One slot leaves on each cycle with `cwr_req`=1 and `cwr_gnt`=1. Slots leave in program order, and two stores to the same address are written separately, with no merging. While the grant is withheld, the request and its address and data stay stable.
- R5: A load whose address equals one or more buffered stores gets `ld_hit`=1 and the data of the youngest matching store.
- R6: A load with no match gets `ld_hit`=0 and `ld_data`=`cache_rd_data`, with `cache_rd_addr`=`ld_addr`, even while older stores to other addresses are still buffered.
- R7: While `fence_full`=1 and any slot is occupied, `ld_block`=1 and `fence_done`=0. Once the queue is empty, `fence_done`=1 and `ld_block`=0.
- R8: With `fence_load`=1 and `fence_full`=0, `fence_done`=1 in the same cycle, `ld_block`=0, and the buffered stores remain in place.
- R9: On a cycle with `flush`=1, all non-retired slots are removed at the next edge, and a store offered in that cycle is dropped. A retire in the same cycle takes effect before the flush. Retired slots keep draining.
- R10: `retire_valid`=1 marks the oldest non-retired slot as retired. It has no effect when no non-retired slot exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Executing store offered |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store can be accepted |
| retire_valid | input | 1 | Retire the oldest non-retired store |
| flush | input | 1 | Remove all non-retired stores |
| ld_addr | input | 32 | Load lookup address |
| ld_hit | output | 1 | Load forwarded from queue |
| ld_data | output | 32 | Load result |
| ld_block | output | 1 | Younger loads must wait |
| cache_rd_addr | output | 32 | Cache read address |
| cache_rd_data | input | 32 | Cache read data (combinational) |
| cwr_req | output | 1 | Cache write request |
| cwr_addr | output | 32 | Cache write address |
| cwr_data | output | 32 | Cache write data |
| cwr_gnt | input | 1 | Cache write accepted |
| fence_full | input | 1 | Heavy fence in progress |
| fence_load | input | 1 | Load-only fence in progress |
| fence_done | output | 1 | Fence may complete |

## Verification
The bench keeps an in-order model of the queue and compares every output on every cycle. The load tests use a repeated address, so that picking the youngest store can be told apart from picking the oldest. A miss is issued while stores to other addresses are buffered, which separates forwarding from cache reads. A drain with the grant withheld and then given separates retirement from commit. A same-address pair checks that the two stores are not merged. Two fence runs are made on the same occupied queue, one with the heavy fence and one with the light fence, to show that only the heavy one blocks loads. A flush is applied over a queue that holds both retired and non-retired slots, including a flush in the same cycle as a retire and a store, to show which slots survive.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sb_slot_t;

    function automatic logic addr_eq(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
        return a == b;
    endfunction
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import tso_sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic             retire_valid,
    input  logic             flush,
    input  logic             fence_full,
    input  logic             cwr_gnt,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic [PTR_W:0]   occ,
    output logic             wr_en,
    output logic             st_ready,
    output logic             cwr_req
);
    localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

    logic [PTR_W:0] head_q, rptr_q, tail_q;
    logic [PTR_W:0] rptr_nx;
    logic [PTR_W:0] n_ret, n_unret;
    logic           retire_fire, commit_fire;

    assign occ      = tail_q - head_q;
    assign n_ret    = rptr_q - head_q;
    assign n_unret  = tail_q - rptr_q;
    assign head_idx = head_q[PTR_W-1:0];
    assign tail_idx = tail_q[PTR_W-1:0];

    assign st_ready    = (occ != FULL_CNT) && !fence_full;
    assign wr_en       = st_valid && st_ready && !flush;
    assign cwr_req     = (n_ret != '0);
    assign commit_fire = cwr_req && cwr_gnt;
    assign retire_fire = retire_valid && (n_unret != '0);
    assign rptr_nx     = rptr_q + (PTR_W+1)'(retire_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            rptr_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + (PTR_W+1)'(commit_fire);
            rptr_q <= rptr_nx;
            if (flush) tail_q <= rptr_nx;
            else       tail_q <= tail_q + (PTR_W+1)'(wr_en);
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);
    a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_CNT) |-> !wr_en);
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (rptr_q == tail_q));
    a_r3_retired_in_range: assert property (@(posedge clk) disable iff (rst)
        n_ret <= occ);
endmodule

// File: rtl/sb_slot_array.sv
module sb_slot_array
    import tso_sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  sb_slot_t              wr_slot,
    input  logic [ADDR_W-1:0]     ld_addr,
    output sb_slot_t [DEPTH-1:0]  slots,
    output logic [DEPTH-1:0]      match
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PTR_W'(i))) slots[i] <= wr_slot;
        end
        assign match[i] = addr_eq(slots[i].addr, ld_addr);
    end
endmodule

// File: rtl/sb_fwd_select.sv
module sb_fwd_select
    import tso_sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sb_slot_t [DEPTH-1:0] slots,
    input  logic [DEPTH-1:0]     match,
    input  logic [PTR_W-1:0]     head_idx,
    input  logic [PTR_W:0]       occ,
    output logic                 hit,
    output logic [DATA_W-1:0]    fwd_data,
    output logic [DEPTH-1:0]     sel
);
    always_comb begin
        sel = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PTR_W-1:0] idx;
            idx = head_idx + PTR_W'(k);
            if (((PTR_W+1)'(k) < occ) && match[idx]) begin
                sel      = '0;
                sel[idx] = 1'b1;
            end
        end
    end

    always_comb begin
        fwd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) fwd_data = slots[i].data;
        end
    end

    assign hit = (sel != '0);

    a_r5_single_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    a_r6_empty_never_hits: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !hit);
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
    import tso_sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              retire_valid,
    input  logic              flush,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_block,
    output logic [ADDR_W-1:0] cache_rd_addr,
    input  logic [DATA_W-1:0] cache_rd_data,
    output logic              cwr_req,
    output logic [ADDR_W-1:0] cwr_addr,
    output logic [DATA_W-1:0] cwr_data,
    input  logic              cwr_gnt,
    input  logic              fence_full,
    input  logic              fence_load,
    output logic              fence_done
);
    localparam int PTR_W = $clog2(DEPTH);

    initial begin
        assert (DEPTH >= 2 && (1 << PTR_W) == DEPTH)
            else $error("DEPTH must be a power of two");
    end

    logic [PTR_W-1:0]     head_idx, tail_idx;
    logic [PTR_W:0]       occ;
    logic                 wr_en;
    sb_slot_t [DEPTH-1:0] slots;
    logic [DEPTH-1:0]     match, sel;
    logic [DATA_W-1:0]    fwd_data;
    sb_slot_t             new_slot;
    logic                 empty;

    assign new_slot = '{addr: st_addr, data: st_data};
    assign empty    = (occ == '0);

    sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk, .rst, .st_valid, .retire_valid, .flush, .fence_full, .cwr_gnt,
        .head_idx, .tail_idx, .occ, .wr_en, .st_ready, .cwr_req
    );

    sb_slot_array #(.DEPTH(DEPTH)) u_slots (
        .clk, .wr_en, .wr_idx(tail_idx), .wr_slot(new_slot), .ld_addr,
        .slots, .match
    );

    sb_fwd_select #(.DEPTH(DEPTH)) u_fwd (
        .clk, .rst, .slots, .match, .head_idx, .occ,
        .hit(ld_hit), .fwd_data, .sel
    );

    assign cache_rd_addr = ld_addr;
    assign ld_data       = ld_hit ? fwd_data : cache_rd_data;
    assign cwr_addr      = slots[head_idx].addr;
    assign cwr_data      = slots[head_idx].data;
    assign ld_block      = fence_full && !empty;
    assign fence_done    = fence_full ? empty : fence_load;

    a_r4_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (cwr_req && !cwr_gnt) |=> (cwr_req && $stable(cwr_addr) && $stable(cwr_data)));
    a_r7_block_excludes_done: assert property (@(posedge clk) disable iff (rst)
        ld_block |-> !fence_done);
    a_r7_no_store_in_fence: assert property (@(posedge clk) disable iff (rst)
        fence_full |-> !st_ready);
    a_r3_req_implies_occupied: assert property (@(posedge clk) disable iff (rst)
        cwr_req |-> !empty);
endmodule

// File: tb/tso_store_buffer_tb_top.sv
module tso_store_buffer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, retire_valid, flush, cwr_gnt, fence_full, fence_load;
    logic [31:0] st_addr, st_data, ld_addr, cache_rd_data;
    logic        st_ready, ld_hit, ld_block, cwr_req, fence_done;
    logic [31:0] ld_data, cache_rd_addr, cwr_addr, cwr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tso_store_buffer #(.DEPTH(DEPTH)) dut_i (
        .clk, .rst, .st_valid, .st_addr, .st_data, .st_ready, .retire_valid,
        .flush, .ld_addr, .ld_hit, .ld_data, .ld_block, .cache_rd_addr,
        .cache_rd_data, .cwr_req, .cwr_addr, .cwr_data, .cwr_gnt,
        .fence_full, .fence_load, .fence_done
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    int          n_ret = 0;
    logic [31:0] mem[logic [31:0]];

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance model at posedge.
    task automatic step(input string tag, input bit sv, input logic [31:0] sa, input logic [31:0] sd,
                        input bit rv, input bit fl, input bit ff, input bit flo, input bit gnt,
                        input logic [31:0] la);
        int occ;
        bit e_ready, e_req, e_hit, e_block, e_done, a_fire, r_fire;
        logic [31:0] e_ld;
        st_valid = sv; st_addr = sa; st_data = sd; retire_valid = rv; flush = fl;
        fence_full = ff; fence_load = flo; cwr_gnt = gnt; ld_addr = la;
        cache_rd_data = mem_rd(la);
        #1;
        occ     = q_addr.size();
        e_ready = (occ < DEPTH) && !ff;
        e_req   = (n_ret > 0);
        e_hit   = 0;
        e_ld    = mem_rd(la);
        foreach (q_addr[i]) if (q_addr[i] == la) begin e_hit = 1; e_ld = q_data[i]; end
        e_block = ff && occ > 0;
        e_done  = ff ? (occ == 0) : flo;
        chk(tag, "R2 st_ready", 32'(st_ready), 32'(e_ready));
        chk(tag, "R3 cwr_req", 32'(cwr_req), 32'(e_req));
        if (e_req) begin
            chk(tag, "R4 cwr_addr", cwr_addr, q_addr[0]);
            chk(tag, "R4 cwr_data", cwr_data, q_data[0]);
        end
        chk(tag, "R5 ld_hit", 32'(ld_hit), 32'(e_hit));
        chk(tag, "R5 ld_data", ld_data, e_ld);
        chk(tag, "R6 cache_rd_addr", cache_rd_addr, la);
        chk(tag, "R7 ld_block", 32'(ld_block), 32'(e_block));
        chk(tag, "R8 fence_done", 32'(fence_done), 32'(e_done));
        a_fire = sv && e_ready && !fl;
        r_fire = rv && (n_ret < occ);
        @(posedge clk);
        if (e_req && gnt) begin
            mem[q_addr[0]] = q_data[0];
            void'(q_addr.pop_front()); void'(q_data.pop_front());
            n_ret--;
        end
        if (r_fire) n_ret++;
        if (fl) begin
            while (q_addr.size() > n_ret) begin
                void'(q_addr.pop_back()); void'(q_data.pop_back());
            end
        end else if (a_fire) begin
            q_addr.push_back(sa); q_data.push_back(sd);
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit gnt, input logic [31:0] la);
        step(tag, 0, 0, 0, 0, 0, 0, 0, gnt, la);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1;
        st_valid = 0; retire_valid = 0; flush = 0; cwr_gnt = 0;
        fence_full = 0; fence_load = 0; st_addr = 0; st_data = 0;
        ld_addr = 0; cache_rd_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1", "st_ready", 32'(st_ready), 1);
        chk("R1", "cwr_req", 32'(cwr_req), 0);
        chk("R1", "ld_hit", 32'(ld_hit), 0);
        chk("R1", "ld_block", 32'(ld_block), 0);
        idle("R1", 1, 32'h100);

        // R5/R6/R3: same address twice, youngest forwarded; unretired never sent
        step("R5", 1, 32'h100, 32'h11, 0, 0, 0, 0, 1, 32'h100);
        step("R5", 1, 32'h200, 32'h22, 0, 0, 0, 0, 1, 32'h100);
        step("R5", 1, 32'h100, 32'h33, 0, 0, 0, 0, 1, 32'h100);
        idle("R5", 1, 32'h100);
        idle("R6", 1, 32'h300);
        idle("R3", 1, 32'h200);

        // R4: retire with grant held off, then drain in order, no merging
        step("R10", 0, 0, 0, 1, 0, 0, 0, 0, 32'h100);
        step("R10", 0, 0, 0, 1, 0, 0, 0, 0, 32'h100);
        step("R10", 0, 0, 0, 1, 0, 0, 0, 0, 32'h100);
        idle("R4", 0, 32'h100);
        idle("R4", 1, 32'h100);
        idle("R4", 1, 32'h100);
        idle("R4", 1, 32'h100);
        idle("R4", 1, 32'h100);
        chk("R4", "mem 0x100", mem_rd(32'h100), 32'h33);

        // R10: retire with nothing to retire
        step("R10", 0, 0, 0, 1, 0, 0, 0, 1, 32'h100);

        // R2: fill beyond capacity
        for (int i = 0; i < DEPTH + 2; i++)
            step("R2", 1, 32'h400 + 32'(i*4), 32'hA0 + 32'(i), 0, 0, 0, 0, 1, 32'h400);
        idle("R2", 1, 32'h41C);
        idle("R2", 1, 32'h420);

        // R8: load fence does not drain
        for (int i = 0; i < 3; i++)
            step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 32'h404);

        // R7: heavy fence waits while stores retire and drain
        step("R7", 1, 32'h500, 32'h55, 0, 0, 1, 0, 1, 32'h404);
        for (int i = 0; i < DEPTH; i++)
            step("R7", 0, 0, 0, 1, 0, 1, 0, (i % 2) == 0, 32'h404);
        for (int i = 0; i < DEPTH + 2; i++)
            step("R7", 0, 0, 0, 0, 0, 1, 0, 1, 32'h404);
        idle("R7", 1, 32'h404);

        // R9: flush over retired + unretired, with same-cycle retire and store
        for (int i = 0; i < 5; i++)
            step("R9", 1, 32'h600 + 32'(i*4), 32'hC0 + 32'(i), 0, 0, 0, 0, 0, 32'h600);
        step("R9", 0, 0, 0, 1, 0, 0, 0, 0, 32'h600);
        step("R9", 1, 32'h700, 32'h77, 1, 1, 0, 0, 0, 32'h608);
        idle("R9", 0, 32'h608);
        idle("R9", 0, 32'h604);
        idle("R9", 1, 32'h700);
        idle("R9", 1, 32'h604);
        idle("R9", 1, 32'h604);
        chk("R9", "mem 0x604", mem_rd(32'h604), 32'hC1);
        chk("R9", "mem 0x608", mem_rd(32'h608), 32'h608 ^ 32'h5A5A_0000);

        finish_run();
    end
endmodule